// File: doc/BRIEF.md
# K Least-Loaded Core Selector

This block gathers load reports from servers, one report naming a server, one of its cores and that core's current load. During a collection window it keeps, in ascending load order, only the K lowest-loaded (server, core) pairs seen so far. At each period tick the working list is copied into a published bank and then cleared. The published bank is what a flow dispatcher reads through an indexed read port until the next tick replaces it.

A report is accepted only if two conditions hold. Its send timestamp must be fresh against the current time and a programmable maximum age. Its server must also not be flagged as congested in a per-server mask. A later report for a pair already held in the working list replaces that pair's load instead of adding a second entry.

Top module: `klow_core_select`

## Requirements
- R1: The working list holds at most K entries in non-decreasing load order. A report that arrives when the list is full and no held entry shares its pair is dropped if its load is not lower than every held load. Otherwise the entry with the highest load (the latest arrival among equal highest loads) leaves the list.
- R2: Entries with equal load are ranked by arrival, the earlier arrival at the lower read index.
- R3: The published entries and `pub_cnt_o` change only on the clock edge where `tick_i` is high. They show the new set from the cycle after that edge.
- R4: A report whose server bit in `cong_i` (bit index = server number) is 1 is ignored.
- R5: A report is ignored when (`now_i` - `rpt_ts_i`) modulo 2^TS_W is greater than `max_age_i`.
- R6: `pub_cnt_o` gives the number of valid published entries, from 0 to K. It is 0 after reset. With fewer than K accepted pairs in a window, only those are published, at indices 0 to `pub_cnt_o`-1.
- R7: An accepted report whose (server, core) matches a held entry removes that entry. It is then placed with its new load as the newest arrival.
- R8: At a tick the working list is emptied after being published. `rpt_ready_o` is low while `tick_i` is high, and a report offered in that cycle is discarded.
- R9: `rd_srv_o`, `rd_core_o` and `rd_load_o` give published entry `rd_idx_i` in the same cycle. Index 0 is the lowest load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | period boundary strobe |
| rpt_valid_i | input | 1 | report offered |
| rpt_ready_o | output | 1 | report can be taken (low during a tick) |
| rpt_srv_i | input | SRV_W | server number of the report |
| rpt_core_i | input | CORE_W | core number within the server |
| rpt_load_i | input | LOAD_W | reported load |
| rpt_ts_i | input | TS_W | timestamp the report was sent at |
| now_i | input | TS_W | current time |
| max_age_i | input | TS_W | largest accepted report age |
| cong_i | input | 2**SRV_W | per-server congestion flags |
| rd_idx_i | input | IW | published entry index |
| rd_srv_o | output | SRV_W | server of the selected entry |
| rd_core_o | output | CORE_W | core of the selected entry |
| rd_load_o | output | LOAD_W | load of the selected entry |
| pub_cnt_o | output | CW | number of valid published entries |

## Verification
The bench builds the block with K = 4, 8 servers of 8 cores, 8-bit loads and 8-bit timestamps. With a capacity of only four, most random windows overflow the list, so eviction and drop decisions are exercised many times. Drawing loads from a range of 0 to 15 makes ties and same-pair replacements frequent. The short timestamp width lets a directed case cross the wrap point of the age subtraction, and random congestion masks over eight servers reject a sizeable share of reports.

// File: rtl/klcs_pkg.sv
package klcs_pkg;
  localparam int SRV_W  = 3;
  localparam int CORE_W = 3;
  localparam int LOAD_W = 8;

  typedef struct packed {
    logic [SRV_W-1:0]  srv;
    logic [CORE_W-1:0] core;
    logic [LOAD_W-1:0] load;
  } slot_t;
endpackage

// File: rtl/klcs_filter.sv
module klcs_filter #(
  parameter int TS_W = 8,
  parameter int SRV_W = 3,
  localparam int NSRV = 2**SRV_W
) (
  input  logic             valid_i,
  input  logic [SRV_W-1:0] srv_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [TS_W-1:0]  now_i,
  input  logic [TS_W-1:0]  max_age_i,
  input  logic [NSRV-1:0]  cong_i,
  output logic             take_o
);
  logic [TS_W-1:0] age;
  assign age    = now_i - ts_i;
  assign take_o = valid_i && !cong_i[srv_i] && (age <= max_age_i);
endmodule

// File: rtl/klcs_list.sv
module klcs_list
  import klcs_pkg::*;
#(
  parameter int K = 4,
  localparam int CW = $clog2(K+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ins_i,
  input  slot_t         new_i,
  output slot_t         ent_o [K],
  output logic [CW-1:0] cnt_o
);
  slot_t         ent_q [K];
  logic [CW-1:0] cnt_q;
  slot_t         rem   [K];
  slot_t         nxt   [K];
  logic          hit;
  int            midx, rcnt, pos;

  // drop a matching pair, then insert after all entries with load <= new
  always_comb begin
    hit  = 1'b0;
    midx = K;
    for (int i = K-1; i >= 0; i--) begin
      if (i < int'(cnt_q) && ent_q[i].srv == new_i.srv && ent_q[i].core == new_i.core) begin
        hit  = 1'b1;
        midx = i;
      end
    end
    for (int i = 0; i < K-1; i++) rem[i] = (hit && i >= midx) ? ent_q[i+1] : ent_q[i];
    rem[K-1] = ent_q[K-1];
    rcnt = int'(cnt_q) - (hit ? 1 : 0);
    pos  = 0;
    for (int j = 0; j < K; j++)
      if (j < rcnt && rem[j].load <= new_i.load) pos++;
    for (int i = 0; i < K; i++) begin
      if (i < pos)       nxt[i] = rem[i];
      else if (i == pos) nxt[i] = new_i;
      else               nxt[i] = rem[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < K; i++) ent_q[i] <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (ins_i && pos < K) begin
      ent_q <= nxt;
      cnt_q <= (rcnt >= K) ? CW'(K) : CW'(rcnt + 1);
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;

  p_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) int'(cnt_q) <= K);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) clr_i |=> cnt_q == '0);
  p_grow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !ins_i |=> $stable(cnt_q));

  for (genvar g = 0; g < K-1; g++) begin : g_ord
    p_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(cnt_q) > g+1 |-> ent_q[g].load <= ent_q[g+1].load);
  end
endmodule

// File: rtl/klcs_pub.sv
module klcs_pub
  import klcs_pkg::*;
#(
  parameter int K = 4,
  localparam int CW = $clog2(K+1),
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  slot_t         ent_i [K],
  input  logic [CW-1:0] cnt_i,
  input  logic [IW-1:0] rd_idx_i,
  output slot_t         rd_o,
  output logic [CW-1:0] cnt_o
);
  slot_t         pub_q [K];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < K; i++) pub_q[i] <= '0;
    end else if (load_i) begin
      cnt_q <= cnt_i;
      pub_q <= ent_i;
    end
  end

  assign rd_o  = (int'(rd_idx_i) < K) ? pub_q[rd_idx_i] : '0;
  assign cnt_o = cnt_q;

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cnt_q) && $stable(pub_q[0]));
  p_take_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(cnt_i));
endmodule

// File: rtl/klow_core_select.sv
module klow_core_select
  import klcs_pkg::*;
#(
  parameter int K    = 4,
  parameter int TS_W = 8,
  localparam int NSRV = 2**SRV_W,
  localparam int CW   = $clog2(K+1),
  localparam int IW   = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rpt_valid_i,
  output logic              rpt_ready_o,
  input  logic [SRV_W-1:0]  rpt_srv_i,
  input  logic [CORE_W-1:0] rpt_core_i,
  input  logic [LOAD_W-1:0] rpt_load_i,
  input  logic [TS_W-1:0]   rpt_ts_i,
  input  logic [TS_W-1:0]   now_i,
  input  logic [TS_W-1:0]   max_age_i,
  input  logic [NSRV-1:0]   cong_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [SRV_W-1:0]  rd_srv_o,
  output logic [CORE_W-1:0] rd_core_o,
  output logic [LOAD_W-1:0] rd_load_o,
  output logic [CW-1:0]     pub_cnt_o
);
  logic          take;
  slot_t         rpt_ent;
  slot_t         w_ent [K];
  logic [CW-1:0] w_cnt;
  slot_t         rd_ent;

  assign rpt_ready_o = !tick_i;
  assign rpt_ent     = '{srv: rpt_srv_i, core: rpt_core_i, load: rpt_load_i};

  klcs_filter #(.TS_W(TS_W), .SRV_W(SRV_W)) u_filter (
    .valid_i(rpt_valid_i), .srv_i(rpt_srv_i), .ts_i(rpt_ts_i), .now_i(now_i),
    .max_age_i(max_age_i), .cong_i(cong_i), .take_o(take)
  );

  klcs_list #(.K(K)) u_list (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tick_i), .ins_i(take && rpt_ready_o),
    .new_i(rpt_ent), .ent_o(w_ent), .cnt_o(w_cnt)
  );

  klcs_pub #(.K(K)) u_pub (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tick_i), .ent_i(w_ent), .cnt_i(w_cnt),
    .rd_idx_i(rd_idx_i), .rd_o(rd_ent), .cnt_o(pub_cnt_o)
  );

  assign rd_srv_o  = rd_ent.srv;
  assign rd_core_o = rd_ent.core;
  assign rd_load_o = rd_ent.load;

  p_cong_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i && rpt_ready_o && cong_i[rpt_srv_i] |=> $stable(w_cnt));
  p_stale_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_valid_i && rpt_ready_o && (TS_W'(now_i - rpt_ts_i) > max_age_i) |=> $stable(w_cnt));
  p_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> !rpt_ready_o);
endmodule

// File: tb/klow_core_select_tb.sv
module klow_core_select_tb;
  localparam int K = 4;
  localparam int TS_W = 8;

  logic       clk = 0, rst_ni = 0, tick = 0, valid = 0;
  logic       ready;
  logic [2:0] srv = 0, core = 0;
  logic [7:0] load = 0, ts = 0, now = 0, max_age = 8'd8, cong = 0;
  logic [1:0] rd_idx = 0;
  logic [2:0] rd_srv, rd_core;
  logic [7:0] rd_load;
  logic [2:0] pcnt;

  int total = 0, bad = 0;
  bit done = 0;
  int seq = 0;
  // model working list (one spare slot) and published copy
  int ms [K+1], mc [K+1], ml [K+1], mq [K+1];
  int mn = 0;
  int ps [K], pc [K], pl [K];
  int pn = 0;

  always #5 clk = ~clk;

  klow_core_select #(.K(K), .TS_W(TS_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rpt_valid_i(valid), .rpt_ready_o(ready),
    .rpt_srv_i(srv), .rpt_core_i(core), .rpt_load_i(load), .rpt_ts_i(ts), .now_i(now),
    .max_age_i(max_age), .cong_i(cong), .rd_idx_i(rd_idx), .rd_srv_o(rd_srv),
    .rd_core_o(rd_core), .rd_load_o(rd_load), .pub_cnt_o(pcnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_add(input int s, input int c, input int l);
    int k;
    for (int i = 0; i < mn; i++)
      if (ms[i] == s && mc[i] == c) begin
        for (int j = i; j < mn-1; j++) begin
          ms[j] = ms[j+1]; mc[j] = mc[j+1]; ml[j] = ml[j+1]; mq[j] = mq[j+1];
        end
        mn--;
        break;
      end
    ms[mn] = s; mc[mn] = c; ml[mn] = l; mq[mn] = seq++;
    k = mn; mn++;
    while (k > 0 && ml[k-1] > ml[k]) begin
      int t;
      t = ms[k]; ms[k] = ms[k-1]; ms[k-1] = t;
      t = mc[k]; mc[k] = mc[k-1]; mc[k-1] = t;
      t = ml[k]; ml[k] = ml[k-1]; ml[k-1] = t;
      t = mq[k]; mq[k] = mq[k-1]; mq[k-1] = t;
      k--;
    end
    if (mn > K) mn = K;
  endtask

  task automatic report(input int s, input int c, input int l, input int n, input int age);
    @(negedge clk);
    srv = 3'(s); core = 3'(c); load = 8'(l); now = 8'(n); ts = 8'(n - age); valid = 1;
    @(posedge clk);
    if (!cong[s] && age <= int'(max_age)) model_add(s, c, l);
    @(negedge clk);
    valid = 0;
  endtask

  task automatic check_pub(input string req);
    chk({req, " count"}, int'(pcnt), pn);
    for (int i = 0; i < pn; i++) begin
      rd_idx = 2'(i);
      #1;
      chk({req, " entry"}, {rd_srv, rd_core, rd_load}, {ps[i][2:0], pc[i][2:0], pl[i][7:0]});
    end
  endtask

  task automatic do_tick(input bit with_rpt);
    @(negedge clk);
    tick = 1;
    if (with_rpt) begin
      srv = 0; core = 0; load = 0; now = 0; ts = 0; valid = 1;
    end
    #1;
    chk("R8 ready low on tick", int'(ready), 0);
    @(posedge clk);
    for (int i = 0; i < mn; i++) begin ps[i] = ms[i]; pc[i] = mc[i]; pl[i] = ml[i]; end
    pn = mn; mn = 0;
    @(negedge clk);
    tick = 0; valid = 0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
    chk("R6 reset count", int'(pcnt), 0);

    // R7 replacement, R2 tie order, R6 partial window
    report(1, 0, 50, 100, 0);
    report(2, 1, 20, 100, 1);
    report(3, 2, 20, 100, 2);
    report(1, 0, 10, 100, 0);
    do_tick(0);
    check_pub("R2 R7 R6 window1");

    // R4 congested, R5 stale incl. timestamp wrap, R1 overflow, R3 hold
    cong = 8'b0010_0000;
    report(5, 0, 1, 50, 0);
    report(6, 0, 2, 3, 9);
    report(6, 1, 3, 3, 6);
    report(4, 0, 40, 60, 0);
    report(4, 1, 30, 60, 0);
    report(4, 2, 30, 60, 0);
    report(4, 3, 35, 60, 0);
    report(4, 4, 90, 60, 0);
    check_pub("R3 hold before tick");
    do_tick(0);
    cong = 0;
    check_pub("R1 R4 R5 window2");

    // R8: report during tick discarded, list cleared
    report(7, 7, 9, 10, 0);
    do_tick(1);
    check_pub("R8 first");
    do_tick(0);
    check_pub("R8 cleared");

    // random windows
    for (int w = 0; w < 60; w++) begin
      int nr;
      cong = 8'($urandom & $urandom);
      nr = $urandom_range(0, 10);
      for (int r = 0; r < nr; r++) begin
        report($urandom_range(0, 7), $urandom_range(0, 2), $urandom_range(0, 15),
               $urandom_range(0, 255), $urandom_range(0, 12));
        if (r == nr/2) check_pub("R3 random hold");
      end
      do_tick(0);
      check_pub("R1 R9 random");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule